// File: doc/BRIEF.md
# DDR2 Rank Command Front End

This block sits at the device side of a DDR2-style memory rank and turns the raw command pins into decoded commands and bookkeeping that the rest of the rank uses. At each rising clock edge it captures the clock enable, chip select, the three command strobes, the bank address, the address bus and the termination request. The captured command is then decoded, checked against the state of the bank it targets, and applied.

The block keeps one open flag and one open row per bank. It holds the four mode registers written by mode-load commands. It drives a termination enable that follows the captured termination request only while the extended mode register turns termination on. Every decoded command, with its bank, column and auto-precharge flag, appears on registered outputs. A command that makes no sense for its bank raises a one-cycle error flag and changes nothing.

Top module: `dram_cmd_front`

## Requirements
- R1: Inputs are captured at a rising clock edge and the decoded command takes effect at the following rising edge. After the capture edge alone, the bank state outputs still show their old values.
- R2: A captured chip select of 1 turns the command into NOP (cmdOut = 0) and leaves all bank and mode state unchanged.
- R3: With chip select 0, {rasN,casN,weN} = 000 gives mode load (cmdOut 1), 001 gives refresh (2), 010 gives precharge (3), 011 gives activate (4), 100 gives write (5) and 101 gives read (6). Any other code gives NOP (0). Refresh changes no bank state.
- R4: An activate to a closed bank opens it and records address bits [ROW_BITS-1:0] as its open row. The row is at openRowFlat[b*ROW_BITS +: ROW_BITS].
- R5: A read or write to an open bank shows its bank on cmdBankOut. It shows the address with bit 10 cleared on cmdColOut and address bit 10 on autoPreOut. When bit 10 is 1, the bank closes at the same edge.
- R6: A precharge with address bit 10 at 0 closes only the addressed bank. With bit 10 at 1 it closes every bank.
- R7: A mode load writes the full address bus into the mode register chosen by bank bits [1:0] (0 MR, 1 EMR, 2 EMR2, 3 EMR3). The registers are at modeRegFlat[i*ADDR_BITS +: ADDR_BITS].
- R8: A captured clock enable of 0 turns the command into NOP with no state change.
- R9: An activate to an open bank, or a read or write to a closed bank, sets illegalCmd for one cycle. The bank state stays unchanged, while cmdOut still shows the command.
- R10: odtEnable is the captured termination input ANDed with (EMR bit 2 OR EMR bit 6), using the EMR value held before the same command's update.
- R11: After reset, all banks are closed, all rows and mode registers are zero, and odtEnable, illegalCmd and cmdOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ckeIn | input | 1 | Clock enable request |
| csN | input | 1 | Active-low chip select |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable |
| bankIn | input | BANK_BITS | Bank address |
| addrIn | input | ADDR_BITS | Row, column or opcode |
| odtIn | input | 1 | Termination request |
| cmdOut | output | 3 | Decoded effective command |
| cmdBankOut | output | BANK_BITS | Bank of the decoded command |
| cmdColOut | output | ADDR_BITS | Column (address with bit 10 cleared) |
| autoPreOut | output | 1 | Bit 10 for read, write or precharge |
| illegalCmd | output | 1 | One-cycle illegal-command pulse |
| bankOpen | output | NUM_BANKS | Open flag per bank |
| openRowFlat | output | NUM_BANKS*ROW_BITS | Open row per bank |
| modeRegFlat | output | 4*ADDR_BITS | Four mode registers |
| odtEnable | output | 1 | Gated termination enable |

## Verification
A wrong open flag surfaces on bankOpen two edges after the command that corrupted it. The next activate, read or write to that bank then raises or misses illegalCmd, so an error in bank state is also reported by the legality check. A wrong mode register value shows up at once on modeRegFlat. When EMR is affected, odtEnable also goes wrong on the next command that carries a termination request. The bench keeps its own bank and mode model and compares every state output after each command, so a fault is caught within the same two-cycle window.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_LMR = 3'd1,
    CMD_REF = 3'd2,
    CMD_PRE = 3'd3,
    CMD_ACT = 3'd4,
    CMD_WR  = 3'd5,
    CMD_RD  = 3'd6
  } cmd_e;

  typedef struct packed {
    logic actStb;
    logic accStb;
    logic closeOne;
    logic closeAll;
    logic lmrStb;
    logic illegal;
  } strobe_t;
endpackage

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl
  import dram_cmd_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int ADDR_BITS = 14,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ckeIn,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_BITS-1:0] bankIn,
  input  logic [ADDR_BITS-1:0] addrIn,
  input  logic                 odtIn,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output logic [BANK_BITS-1:0] bankQ,
  output logic [ADDR_BITS-1:0] addrQ,
  output logic                 odtQ,
  output cmd_e                 cmd,
  output strobe_t              stb
);
  logic ckeQ, csQ, rasQ, casQ, weQ;
  logic bankHit, isAccess;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeQ  <= 1'b0;
      csQ   <= 1'b1;
      rasQ  <= 1'b1;
      casQ  <= 1'b1;
      weQ   <= 1'b1;
      bankQ <= '0;
      addrQ <= '0;
      odtQ  <= 1'b0;
    end else begin
      ckeQ  <= ckeIn;
      csQ   <= csN;
      rasQ  <= rasN;
      casQ  <= casN;
      weQ   <= weN;
      bankQ <= bankIn;
      addrQ <= addrIn;
      odtQ  <= odtIn;
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (ckeQ && !csQ) begin
      case ({rasQ, casQ, weQ})
        3'b000:  cmd = CMD_LMR;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign bankHit  = bankOpen[bankQ];
  assign isAccess = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    stb          = '0;
    stb.actStb   = (cmd == CMD_ACT) && !bankHit;
    stb.accStb   = isAccess && bankHit;
    stb.illegal  = ((cmd == CMD_ACT) && bankHit) || (isAccess && !bankHit);
    stb.closeAll = (cmd == CMD_PRE) && addrQ[AP_BIT];
    stb.closeOne = ((cmd == CMD_PRE) && !addrQ[AP_BIT]) ||
                   (stb.accStb && addrQ[AP_BIT]);
    stb.lmrStb   = (cmd == CMD_LMR);
  end
endmodule

// File: rtl/dram_cmd_dp.sv
module dram_cmd_dp
  import dram_cmd_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int ADDR_BITS = 14,
  parameter int ROW_BITS  = 14,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [BANK_BITS-1:0]          bankQ,
  input  logic [ADDR_BITS-1:0]          addrQ,
  input  logic                          odtQ,
  input  cmd_e                          cmd,
  input  strobe_t                       stb,
  output logic [2:0]                    cmdOut,
  output logic [BANK_BITS-1:0]          cmdBankOut,
  output logic [ADDR_BITS-1:0]          cmdColOut,
  output logic                          autoPreOut,
  output logic                          illegalCmd,
  output logic [NUM_BANKS-1:0]          bankOpen,
  output logic [NUM_BANKS*ROW_BITS-1:0] openRowFlat,
  output logic [4*ADDR_BITS-1:0]        modeRegFlat,
  output logic                          odtEnable
);
  localparam logic [ADDR_BITS-1:0] AP_MASK = ADDR_BITS'(1) << AP_BIT;

  logic rttOn;
  logic usesAp;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic selThis;
    assign selThis = (bankQ == BANK_BITS'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
        openRowFlat[b*ROW_BITS +: ROW_BITS] <= '0;
      end else if (stb.closeAll || (stb.closeOne && selThis)) begin
        bankOpen[b] <= 1'b0;
      end else if (stb.actStb && selThis) begin
        bankOpen[b] <= 1'b1;
        openRowFlat[b*ROW_BITS +: ROW_BITS] <= addrQ[ROW_BITS-1:0];
      end
    end
  end

  for (genvar m = 0; m < 4; m++) begin : g_mode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        modeRegFlat[m*ADDR_BITS +: ADDR_BITS] <= '0;
      else if (stb.lmrStb && (bankQ[1:0] == 2'(m)))
        modeRegFlat[m*ADDR_BITS +: ADDR_BITS] <= addrQ;
    end
  end

  assign rttOn  = modeRegFlat[ADDR_BITS + 2] | modeRegFlat[ADDR_BITS + 6];
  assign usesAp = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_PRE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut     <= '0;
      cmdBankOut <= '0;
      cmdColOut  <= '0;
      autoPreOut <= 1'b0;
      illegalCmd <= 1'b0;
      odtEnable  <= 1'b0;
    end else begin
      cmdOut     <= cmd;
      cmdBankOut <= bankQ;
      cmdColOut  <= addrQ & ~AP_MASK;
      autoPreOut <= usesAp & addrQ[AP_BIT];
      illegalCmd <= stb.illegal;
      odtEnable  <= odtQ & rttOn;
    end
  end
endmodule

// File: rtl/dram_cmd_front.sv
module dram_cmd_front
  import dram_cmd_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int ADDR_BITS = 14,
  parameter int ROW_BITS  = 14,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ckeIn,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic [BANK_BITS-1:0]          bankIn,
  input  logic [ADDR_BITS-1:0]          addrIn,
  input  logic                          odtIn,
  output logic [2:0]                    cmdOut,
  output logic [BANK_BITS-1:0]          cmdBankOut,
  output logic [ADDR_BITS-1:0]          cmdColOut,
  output logic                          autoPreOut,
  output logic                          illegalCmd,
  output logic [NUM_BANKS-1:0]          bankOpen,
  output logic [NUM_BANKS*ROW_BITS-1:0] openRowFlat,
  output logic [4*ADDR_BITS-1:0]        modeRegFlat,
  output logic                          odtEnable
);
  logic [BANK_BITS-1:0] bankQ;
  logic [ADDR_BITS-1:0] addrQ;
  logic                 odtQ;
  cmd_e                 cmd;
  strobe_t              stb;

  dram_cmd_ctrl #(.BANK_BITS(BANK_BITS), .ADDR_BITS(ADDR_BITS), .AP_BIT(AP_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .ckeIn(ckeIn), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankIn(bankIn), .addrIn(addrIn), .odtIn(odtIn), .bankOpen(bankOpen),
    .bankQ(bankQ), .addrQ(addrQ), .odtQ(odtQ), .cmd(cmd), .stb(stb)
  );

  dram_cmd_dp #(.BANK_BITS(BANK_BITS), .ADDR_BITS(ADDR_BITS), .ROW_BITS(ROW_BITS),
                .AP_BIT(AP_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .bankQ(bankQ), .addrQ(addrQ), .odtQ(odtQ), .cmd(cmd),
    .stb(stb), .cmdOut(cmdOut), .cmdBankOut(cmdBankOut), .cmdColOut(cmdColOut),
    .autoPreOut(autoPreOut), .illegalCmd(illegalCmd), .bankOpen(bankOpen),
    .openRowFlat(openRowFlat), .modeRegFlat(modeRegFlat), .odtEnable(odtEnable)
  );
endmodule

// File: rtl/dram_cmd_front_chk.sv
module dram_cmd_front_chk #(
  parameter int BANK_BITS = 3,
  parameter int ADDR_BITS = 14,
  parameter int ROW_BITS  = 14,
  parameter int AP_BIT    = 10,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [2:0]                    cmdOut,
  input logic [BANK_BITS-1:0]          cmdBankOut,
  input logic                          autoPreOut,
  input logic                          illegalCmd,
  input logic [NUM_BANKS-1:0]          bankOpen,
  input logic [4*ADDR_BITS-1:0]        modeRegFlat,
  input logic                          odtEnable
);
  // R9: an illegal command leaves the open flags as they were
  a_r9_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> bankOpen == $past(bankOpen));

  // R9: only activate, read or write can be flagged
  a_r9_illegal_kind: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> (cmdOut == 3'd4 || cmdOut == 3'd5 || cmdOut == 3'd6));

  // R4: a legal activate leaves its bank open
  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 3'd4 && !illegalCmd) |-> bankOpen[cmdBankOut]);

  // R6: an all-bank precharge leaves nothing open
  a_r6_pre_all: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 3'd3 && autoPreOut) |-> bankOpen == '0);

  // R10: termination only when the prior EMR enabled it
  a_r10_odt_gate: assert property (@(posedge clk) disable iff (!rstN)
    odtEnable |-> ($past(modeRegFlat[ADDR_BITS + 2]) || $past(modeRegFlat[ADDR_BITS + 6])));

  // R2: a NOP changes no open flag
  a_r2_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 3'd0) |-> bankOpen == $past(bankOpen));
endmodule

bind dram_cmd_front dram_cmd_front_chk #(
  .BANK_BITS(BANK_BITS), .ADDR_BITS(ADDR_BITS), .ROW_BITS(ROW_BITS), .AP_BIT(AP_BIT)
) chk_i (.*);

// File: tb/dram_cmd_front_tb_top.sv
module dram_cmd_front_tb_top;
  localparam int BB = 3;
  localparam int AB = 14;
  localparam int RB = 14;
  localparam int NB = 1 << BB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckeIn = 1'b0, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, odtIn = 1'b0;
  logic [BB-1:0] bankIn = '0;
  logic [AB-1:0] addrIn = '0;
  logic [2:0] cmdOut;
  logic [BB-1:0] cmdBankOut;
  logic [AB-1:0] cmdColOut;
  logic autoPreOut, illegalCmd, odtEnable;
  logic [NB-1:0] bankOpen;
  logic [NB*RB-1:0] openRowFlat;
  logic [4*AB-1:0] modeRegFlat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NB-1:0]  mOpen = '0;
  logic [RB-1:0]  mRow [NB];
  logic [AB-1:0]  mMr [4];

  always #4 clk = ~clk;

  dram_cmd_front dut_i (
    .clk(clk), .rstN(rstN), .ckeIn(ckeIn), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankIn(bankIn), .addrIn(addrIn), .odtIn(odtIn), .cmdOut(cmdOut),
    .cmdBankOut(cmdBankOut), .cmdColOut(cmdColOut), .autoPreOut(autoPreOut),
    .illegalCmd(illegalCmd), .bankOpen(bankOpen), .openRowFlat(openRowFlat),
    .modeRegFlat(modeRegFlat), .odtEnable(odtEnable)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NB*RB-1:0] rowsFlat();
    logic [NB*RB-1:0] r;
    for (int b = 0; b < NB; b++) r[b*RB +: RB] = mRow[b];
    return r;
  endfunction

  function automatic logic [4*AB-1:0] mrFlat();
    logic [4*AB-1:0] r;
    for (int m = 0; m < 4; m++) r[m*AB +: AB] = mMr[m];
    return r;
  endfunction

  // code = {cs, ras, cas, we}
  task automatic doCmd(input string req, input logic [3:0] code, input int ba,
                       input logic [AB-1:0] a, input logic cke, input logic odt);
    int expCmd;
    logic expIll, expOdt, hit;
    logic [NB-1:0] oldOpen;
    expCmd = 0;
    if (cke && !code[3]) begin
      case (code[2:0])
        3'b000: expCmd = 1;
        3'b001: expCmd = 2;
        3'b010: expCmd = 3;
        3'b011: expCmd = 4;
        3'b100: expCmd = 5;
        3'b101: expCmd = 6;
        default: expCmd = 0;
      endcase
    end
    expOdt = odt & (mMr[1][2] | mMr[1][6]);
    hit = mOpen[ba];
    expIll = (expCmd == 4 && hit) || ((expCmd == 5 || expCmd == 6) && !hit);
    oldOpen = mOpen;
    if (!expIll) begin
      case (expCmd)
        1: mMr[ba % 4] = a;
        3: if (a[10]) mOpen = '0; else mOpen[ba] = 1'b0;
        4: begin mOpen[ba] = 1'b1; mRow[ba] = a[RB-1:0]; end
        5, 6: if (a[10]) mOpen[ba] = 1'b0;
        default: ;
      endcase
    end
    {csN, rasN, casN, weN} = code;
    bankIn = BB'(ba);
    addrIn = a;
    ckeIn = cke;
    odtIn = odt;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "state held after capture edge", 128'(bankOpen), 128'(oldOpen));
    {csN, rasN, casN, weN} = 4'b1111;
    ckeIn = 1'b1;
    odtIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req, "cmdOut", 128'(cmdOut), 128'(expCmd));
    chk(req, "illegalCmd", 128'(illegalCmd), 128'(expIll));
    chk(req, "bankOpen", 128'(bankOpen), 128'(mOpen));
    chk(req, "openRowFlat", 128'(openRowFlat), 128'(rowsFlat()));
    chk(req, "modeRegFlat", 128'(modeRegFlat), 128'(mrFlat()));
    chk(req, "odtEnable", 128'(odtEnable), 128'(expOdt));
    if (expCmd == 5 || expCmd == 6) begin
      chk(req, "cmdBankOut", 128'(cmdBankOut), 128'(ba));
      chk(req, "cmdColOut", 128'(cmdColOut), 128'(a & ~(AB'(1) << 10)));
      chk(req, "autoPreOut", 128'(autoPreOut), 128'(a[10]));
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) mRow[b] = '0;
    for (int m = 0; m < 4; m++) mMr[m] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", "bankOpen", 128'(bankOpen), 128'(0));
    chk("R11", "openRowFlat", 128'(openRowFlat), 128'(0));
    chk("R11", "modeRegFlat", 128'(modeRegFlat), 128'(0));
    chk("R11", "cmdOut", 128'(cmdOut), 128'(0));
    chk("R11", "illegalCmd", 128'(illegalCmd), 128'(0));
    chk("R11", "odtEnable", 128'(odtEnable), 128'(0));
    rstN = 1'b1;
    ckeIn = 1'b1;
    @(negedge clk);

    for (int b = 0; b < NB; b++) doCmd("R4", 4'b0011, b, AB'(b * 301 + 7), 1'b1, 1'b0);
    for (int b = 0; b < NB; b++) doCmd("R9", 4'b0011, b, AB'(b * 17 + 1), 1'b1, 1'b0);
    for (int b = 0; b < NB; b++) doCmd("R5", 4'b0101, b, AB'(b * 8 + 3), 1'b1, 1'b0);
    doCmd("R5", 4'b0100, 0, AB'(14'h0400 | 14'h2a5), 1'b1, 1'b0);
    doCmd("R9", 4'b0101, 0, AB'(9), 1'b1, 1'b0);
    doCmd("R9", 4'b0100, 0, AB'(9), 1'b1, 1'b0);
    doCmd("R2", 4'b1011, 0, AB'(55), 1'b1, 1'b0);
    doCmd("R2", 4'b1010, 3, AB'(14'h0400), 1'b1, 1'b0);
    doCmd("R8", 4'b0011, 0, AB'(66), 1'b0, 1'b0);
    doCmd("R8", 4'b0010, 2, AB'(14'h0400), 1'b0, 1'b0);
    doCmd("R3", 4'b0110, 4, AB'(14'h0400), 1'b1, 1'b0);
    doCmd("R3", 4'b0111, 4, AB'(0), 1'b1, 1'b0);
    doCmd("R3", 4'b0001, 5, AB'(14'h0400), 1'b1, 1'b0);
    doCmd("R6", 4'b0010, 1, AB'(0), 1'b1, 1'b0);
    doCmd("R6", 4'b0010, 1, AB'(0), 1'b1, 1'b0);
    doCmd("R6", 4'b0010, 0, AB'(14'h0400), 1'b1, 1'b0);
    doCmd("R4", 4'b0011, 6, AB'(14'h3fff), 1'b1, 1'b0);
    doCmd("R5", 4'b0101, 6, AB'(14'h3fff), 1'b1, 1'b0);
    for (int m = 0; m < 4; m++) doCmd("R7", 4'b0000, m, AB'(m * 1111 + 16'h0808), 1'b1, 1'b0);
    doCmd("R7", 4'b0000, 4 + 3, AB'(14'h1234), 1'b1, 1'b0);
    doCmd("R10", 4'b0111, 0, AB'(0), 1'b1, 1'b1);
    doCmd("R10", 4'b0000, 1, AB'(14'h0004), 1'b1, 1'b1);
    doCmd("R10", 4'b0111, 0, AB'(0), 1'b1, 1'b1);
    doCmd("R10", 4'b0111, 0, AB'(0), 1'b1, 1'b0);
    doCmd("R10", 4'b0000, 1, AB'(14'h0040), 1'b1, 1'b0);
    doCmd("R10", 4'b1111, 0, AB'(0), 1'b0, 1'b1);
    doCmd("R10", 4'b0000, 1, AB'(14'h3fbb), 1'b1, 1'b1);
    doCmd("R10", 4'b0111, 0, AB'(0), 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule